// File: doc/BRIEF.md
# Partial-Region Memory Mirroring Controller

This controller sits between one requester and two memory banks, a primary and a secondary. Software programs a window with a base and a limit register. Only addresses inside that window keep a second copy. Writes in the window go to both banks. Writes outside it go to the primary alone. The requester sees one plain command port, whichever bank serves it.

Reads in the window normally come from the primary. If the primary reports an uncorrectable error for a windowed read, the controller reads the secondary copy, returns that data, and writes it back to the primary. It then bumps a recovery counter. The requester only sees a longer response time. A sticky failover mode sends every windowed read straight to the secondary. Software can set it, and it also sets itself once a fixed number of primary uncorrectable errors has been seen in the window. Only reset clears it.

Top module: `mirror_ctrl`

## Requirements
- R1: An address is mirrored exactly when win_base <= addr < win_limit. An empty window (limit <= base) mirrors nothing.
- R2: A windowed write is issued to both banks. req_ready stays low until both banks have accepted it, whichever bank is slower.
- R3: A write outside the window is issued to the primary only, and the secondary sees no command.
- R4: With failover clear, a windowed read is served by the primary without touching the secondary. If the primary reports no error, the read returns the primary data with rsp_err = 0.
- R5: When the primary flags pa_uerr = 1 on a windowed read, the controller reads the secondary and returns its data with rsp_err = 0.
- R6: After such a recovery, the secondary data is written back to the primary at the same address before the response, and recover_count rises by exactly one.
- R7: If both banks flag an uncorrectable error for the same windowed read, the response carries rsp_err = 1 and recover_count is unchanged.
- R8: A primary uncorrectable error outside the window returns rsp_err = 1 and causes no secondary access.
- R9: A one-cycle pulse on failover_set makes failover 1 until reset. While it is set, windowed reads go only to the secondary with no write-back, and reads outside the window still go to the primary.
- R10: failover sets by itself once FAIL_THRESH windowed primary reads have returned uncorrectable errors (default 4). It stays clear before that count is reached.
- R11: After reset, failover = 0, recover_count = 0, req_ready = 0, and neither bank command valid is high.
- R12: A request is held by the requester until req_ready is seen. req_ready is a single-cycle pulse, and for a read rsp_valid is high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_base | input | ADDR_W | First mirrored address |
| win_limit | input | ADDR_W | First address past the window |
| failover_set | input | 1 | Pulse that forces failover mode |
| failover | output | 1 | Sticky failover state |
| recover_count | output | CNT_W | Number of words repaired from the secondary |
| req_valid | input | 1 | Request present, held until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request completed (one cycle) |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | DATA_W | Read data |
| rsp_err | output | 1 | Read could not be recovered |
| pa_valid | output | 1 | Primary command valid |
| pa_write | output | 1 | Primary command is a write |
| pa_addr | output | ADDR_W | Primary address |
| pa_wdata | output | DATA_W | Primary write data |
| pa_ready | input | 1 | Primary accepts command |
| pa_rvalid | input | 1 | Primary read data valid |
| pa_rdata | input | DATA_W | Primary read data |
| pa_uerr | input | 1 | Primary read data uncorrectable |
| pb_valid | output | 1 | Secondary command valid |
| pb_write | output | 1 | Secondary command is a write |
| pb_addr | output | ADDR_W | Secondary address |
| pb_wdata | output | DATA_W | Secondary write data |
| pb_ready | input | 1 | Secondary accepts command |
| pb_rvalid | input | 1 | Secondary read data valid |
| pb_rdata | input | DATA_W | Secondary read data |
| pb_uerr | input | 1 | Secondary read data uncorrectable |

## Verification
The hardest case to reach from the ports is the automatic switch to failover. It needs several separate windowed reads to each see a primary uncorrectable error, and each successful recovery rewrites and heals the primary word. The bench's bank models take a poison command per address, so the stimulus poisons a new address before each read and steps the error count up to one below the threshold and then onto it. The dual-write stall is reached by giving the two bank models different accept latencies, first one way round and then the other.

// File: rtl/mirror_ctrl.sv
module mirror_ctrl #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 16,
  parameter int FAIL_THRESH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] win_base,
  input  logic [ADDR_W-1:0] win_limit,
  input  logic              failover_set,
  output logic              failover,
  output logic [CNT_W-1:0]  recover_count,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  output logic              pa_valid,
  output logic              pa_write,
  output logic [ADDR_W-1:0] pa_addr,
  output logic [DATA_W-1:0] pa_wdata,
  input  logic              pa_ready,
  input  logic              pa_rvalid,
  input  logic [DATA_W-1:0] pa_rdata,
  input  logic              pa_uerr,
  output logic              pb_valid,
  output logic              pb_write,
  output logic [ADDR_W-1:0] pb_addr,
  output logic [DATA_W-1:0] pb_wdata,
  input  logic              pb_ready,
  input  logic              pb_rvalid,
  input  logic [DATA_W-1:0] pb_rdata,
  input  logic              pb_uerr
);

  localparam int PERR_W = $clog2(FAIL_THRESH + 1);
  localparam logic [PERR_W-1:0] PERR_MAX = PERR_W'(FAIL_THRESH);

  typedef enum logic [2:0] {
    S_IDLE, S_WR, S_RDP, S_WTP, S_RDS, S_WTS, S_FIX, S_DONE
  } state_t;

  state_t            state;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_data;
  logic              cur_wr, cur_in, a_ok, b_ok, via_fail, err_r, fo_r;
  logic [PERR_W-1:0] perr_cnt;
  logic [CNT_W-1:0]  rec_cnt;

  wire win_hit = (req_addr >= win_base) && (req_addr < win_limit);
  wire acc_a   = pa_valid && pa_ready;
  wire acc_b   = pb_valid && pb_ready;
  wire wr_done = (a_ok || acc_a) && (!cur_in || b_ok || acc_b);

  assign pa_valid = (state == S_WR && !a_ok) || state == S_RDP || state == S_FIX;
  assign pa_write = (state == S_WR) || (state == S_FIX);
  assign pa_addr  = cur_addr;
  assign pa_wdata = cur_data;
  assign pb_valid = (state == S_WR && cur_in && !b_ok) || state == S_RDS;
  assign pb_write = (state == S_WR);
  assign pb_addr  = cur_addr;
  assign pb_wdata = cur_data;

  assign req_ready     = (state == S_DONE);
  assign rsp_valid     = (state == S_DONE) && !cur_wr;
  assign rsp_data      = cur_data;
  assign rsp_err       = err_r;
  assign failover      = fo_r;
  assign recover_count = rec_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur_addr <= '0;
      cur_data <= '0;
      cur_wr   <= 1'b0;
      cur_in   <= 1'b0;
      a_ok     <= 1'b0;
      b_ok     <= 1'b0;
      via_fail <= 1'b0;
      err_r    <= 1'b0;
      perr_cnt <= '0;
      rec_cnt  <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          cur_addr <= req_addr;
          cur_data <= req_wdata;
          cur_wr   <= req_write;
          cur_in   <= win_hit;
          a_ok     <= 1'b0;
          b_ok     <= 1'b0;
          via_fail <= 1'b0;
          err_r    <= 1'b0;
          if (req_write)            state <= S_WR;
          else if (win_hit && fo_r) state <= S_RDS;
          else                      state <= S_RDP;
        end
        S_WR: begin
          a_ok <= a_ok || acc_a;
          b_ok <= b_ok || acc_b;
          if (wr_done) state <= S_DONE;
        end
        S_RDP: if (pa_ready) state <= S_WTP;
        S_WTP: if (pa_rvalid) begin
          cur_data <= pa_rdata;
          if (!pa_uerr) begin
            state <= S_DONE;
          end else if (cur_in) begin
            via_fail <= 1'b1;
            if (perr_cnt != PERR_MAX) perr_cnt <= perr_cnt + 1'b1;
            state <= S_RDS;
          end else begin
            err_r <= 1'b1;
            state <= S_DONE;
          end
        end
        S_RDS: if (pb_ready) state <= S_WTS;
        S_WTS: if (pb_rvalid) begin
          cur_data <= pb_rdata;
          if (pb_uerr) begin
            err_r <= 1'b1;
            state <= S_DONE;
          end else if (via_fail) begin
            state <= S_FIX;
          end else begin
            state <= S_DONE;
          end
        end
        S_FIX: if (pa_ready) begin
          rec_cnt <= rec_cnt + 1'b1;
          state   <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       fo_r <= 1'b0;
    else if (failover_set)            fo_r <= 1'b1;
    else if (perr_cnt == PERR_MAX)    fo_r <= 1'b1;
  end

  p_fo_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    failover |=> failover);

  p_sec_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pb_valid |-> (pb_addr >= win_base) && (pb_addr < win_limit));

  p_rsp_with_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  p_ready_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (recover_count != $past(recover_count)) |-> (recover_count == $past(recover_count) + 1'b1));

  p_pa_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_valid && !pa_ready) |=> (pa_valid && $stable(pa_addr) && $stable(pa_write)));

endmodule

// File: tb/test_mirror_ctrl.sv
module tb_bank (
  input  logic        clk,
  input  logic        rst_n,
  input  int          lat,
  input  logic        poke,
  input  logic [7:0]  poke_addr,
  input  logic        valid,
  input  logic        write,
  input  logic [7:0]  addr,
  input  logic [15:0] wdata,
  output logic        ready,
  output logic        rvalid,
  output logic [15:0] rdata,
  output logic        uerr,
  output int          wr_n,
  output int          rd_n
);
  logic [15:0] mem [256];
  logic        bad [256];
  int          hold;
  logic        p1_v, p2_v, p1_e, p2_e;
  logic [15:0] p1_d, p2_d;

  assign ready  = valid && (hold >= lat);
  assign rvalid = p2_v;
  assign rdata  = p2_d;
  assign uerr   = p2_e;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin mem[i] <= 16'h0; bad[i] <= 1'b0; end
      hold <= 0; wr_n <= 0; rd_n <= 0;
      p1_v <= 0; p2_v <= 0; p1_e <= 0; p2_e <= 0; p1_d <= 0; p2_d <= 0;
    end else begin
      hold <= (valid && !ready) ? hold + 1 : 0;
      if (poke) bad[poke_addr] <= 1'b1;
      if (valid && ready) begin
        if (write) begin
          mem[addr] <= wdata; bad[addr] <= 1'b0; wr_n <= wr_n + 1;
        end else rd_n <= rd_n + 1;
      end
      p1_v <= valid && ready && !write;
      p1_d <= mem[addr];
      p1_e <= bad[addr];
      p2_v <= p1_v; p2_d <= p1_d; p2_e <= p1_e;
    end
  end
endmodule

module test_mirror_ctrl;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [7:0] win_base = 8'h20, win_limit = 8'h40;
  logic failover_set = 0, failover;
  logic [15:0] recover_count;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic req_ready, rsp_valid, rsp_err;
  logic [15:0] rsp_data;
  logic pa_valid, pa_write, pa_ready, pa_rvalid, pa_uerr;
  logic pb_valid, pb_write, pb_ready, pb_rvalid, pb_uerr;
  logic [7:0] pa_addr, pb_addr;
  logic [15:0] pa_wdata, pb_wdata, pa_rdata, pb_rdata;
  int a_lat = 0, b_lat = 0, a_wr, a_rd, b_wr, b_rd;
  logic poke_a = 0, poke_b = 0;
  logic [7:0] poke_addr = 0;

  int total = 0, bad = 0;

  mirror_ctrl i_mirror_ctrl (.*);

  tb_bank i_bank_a (.clk, .rst_n, .lat(a_lat), .poke(poke_a), .poke_addr,
    .valid(pa_valid), .write(pa_write), .addr(pa_addr), .wdata(pa_wdata),
    .ready(pa_ready), .rvalid(pa_rvalid), .rdata(pa_rdata), .uerr(pa_uerr),
    .wr_n(a_wr), .rd_n(a_rd));
  tb_bank i_bank_b (.clk, .rst_n, .lat(b_lat), .poke(poke_b), .poke_addr,
    .valid(pb_valid), .write(pb_write), .addr(pb_addr), .wdata(pb_wdata),
    .ready(pb_ready), .rvalid(pb_rvalid), .rdata(pb_rdata), .uerr(pb_uerr),
    .wr_n(b_wr), .rd_n(b_rd));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [15:0] got_d;
  logic got_e, got_v;

  task automatic run_op(input logic wr, input logic [7:0] ad, input logic [15:0] d);
    bit seen = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = ad; req_wdata = d;
    for (int k = 0; k < 100 && !seen; k++) begin
      @(negedge clk);
      if (req_ready) seen = 1;
    end
    got_d = rsp_data; got_e = rsp_err; got_v = rsp_valid;
    req_valid = 0;
    if (!seen) chk("R12 watchdog", 0, 1);
    else if (!wr) chk("R12 rsp_valid with ready", got_v, 1);
  endtask

  task automatic poison(input bit on_a, input bit on_b, input logic [7:0] ad);
    @(negedge clk);
    poke_addr = ad; poke_a = on_a; poke_b = on_b;
    @(negedge clk);
    poke_a = 0; poke_b = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R11 ready", req_ready, 0);
    chk("R11 failover", failover, 0);
    chk("R11 count", recover_count, 0);
    chk("R11 pa_valid", pa_valid, 0);
    chk("R11 pb_valid", pb_valid, 0);
    rst_n = 1;
    @(negedge clk);
  endtask

  localparam logic [24:0] TBL [8] = '{
    {1'b1, 8'h20, 16'hA1A1}, {1'b1, 8'h3F, 16'h3F3F},
    {1'b1, 8'h40, 16'h4040}, {1'b1, 8'h1F, 16'h1F1F},
    {1'b0, 8'h20, 16'hA1A1}, {1'b0, 8'h3F, 16'h3F3F},
    {1'b0, 8'h40, 16'h4040}, {1'b0, 8'h1F, 16'h1F1F}
  };

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int a0, b0, bw0, c0;
    do_reset();

    for (int i = 0; i < 8; i++) begin
      logic w; logic [7:0] ad; logic [15:0] d; bit inw;
      {w, ad, d} = TBL[i];
      inw = (ad >= win_base) && (ad < win_limit);
      bw0 = b_wr; b0 = b_rd;
      run_op(w, ad, d);
      if (w) begin
        chk(inw ? "R1 R2 mirrored write" : "R1 R3 unmirrored write", b_wr - bw0, inw ? 1 : 0);
        if (inw) chk("R2 secondary data", i_bank_b.mem[ad], d);
      end else begin
        chk("R4 read data", got_d, d);
        chk("R4 read err", got_e, 0);
        chk("R4 secondary untouched", b_rd - b0, 0);
      end
    end

    a_lat = 4; b_lat = 0;
    a0 = a_wr; bw0 = b_wr;
    run_op(1, 8'h25, 16'h2525);
    chk("R2 slow primary both accepted", (a_wr - a0) * 10 + (b_wr - bw0), 11);
    a_lat = 0; b_lat = 5;
    a0 = a_wr; bw0 = b_wr;
    run_op(1, 8'h26, 16'h2626);
    chk("R2 slow secondary both accepted", (a_wr - a0) * 10 + (b_wr - bw0), 11);
    b_lat = 1;

    run_op(1, 8'h30, 16'h5A5A);
    poison(1, 0, 8'h30);
    b0 = b_rd; c0 = recover_count;
    run_op(0, 8'h30, 0);
    chk("R5 recovered data", got_d, 16'h5A5A);
    chk("R5 recovered err", got_e, 0);
    chk("R5 secondary read", b_rd - b0, 1);
    chk("R6 count", recover_count, c0 + 1);
    chk("R6 primary repaired", i_bank_a.bad[8'h30], 0);
    chk("R6 primary data", i_bank_a.mem[8'h30], 16'h5A5A);
    b0 = b_rd;
    run_op(0, 8'h30, 0);
    chk("R6 healed read no secondary", b_rd - b0, 0);

    run_op(1, 8'h31, 16'h1111);
    poison(1, 1, 8'h31);
    c0 = recover_count;
    run_op(0, 8'h31, 0);
    chk("R7 double error flag", got_e, 1);
    chk("R7 count unchanged", recover_count, c0);

    run_op(1, 8'h50, 16'h5050);
    poison(1, 0, 8'h50);
    b0 = b_rd;
    run_op(0, 8'h50, 0);
    chk("R8 outside err", got_e, 1);
    chk("R8 no secondary", b_rd - b0, 0);

    run_op(1, 8'h32, 16'h3232);
    poison(1, 0, 8'h32);
    run_op(0, 8'h32, 0);
    repeat (2) @(negedge clk);
    chk("R10 below threshold", failover, 0);
    run_op(1, 8'h33, 16'h3333);
    poison(1, 0, 8'h33);
    run_op(0, 8'h33, 0);
    chk("R10 last recovered data", got_d, 16'h3333);
    repeat (2) @(negedge clk);
    chk("R10 threshold failover", failover, 1);
    a0 = a_rd; b0 = b_rd;
    run_op(0, 8'h20, 0);
    chk("R10 routed secondary", (a_rd - a0) * 10 + (b_rd - b0), 1);
    chk("R10 routed data", got_d, 16'hA1A1);

    do_reset();
    run_op(1, 8'h28, 16'h0077);
    @(negedge clk); failover_set = 1; @(negedge clk); failover_set = 0;
    repeat (3) @(negedge clk);
    chk("R9 failover set", failover, 1);
    a0 = a_rd; b0 = b_rd; c0 = recover_count;
    run_op(0, 8'h28, 0);
    chk("R9 window read secondary only", (a_rd - a0) * 10 + (b_rd - b0), 1);
    chk("R9 data", got_d, 16'h0077);
    chk("R9 no writeback", recover_count, c0);
    run_op(1, 8'h10, 16'h1010);
    a0 = a_rd; b0 = b_rd;
    run_op(0, 8'h10, 0);
    chk("R9 outside read primary", (a_rd - a0) * 10 + (b_rd - b0), 10);

    win_base = 8'h40; win_limit = 8'h40;
    bw0 = b_wr;
    run_op(1, 8'h40, 16'h4444);
    chk("R1 empty window", b_wr - bw0, 0);
    win_base = 8'h40; win_limit = 8'h30;
    bw0 = b_wr;
    run_op(1, 8'h38, 16'h3838);
    chk("R1 inverted window", b_wr - bw0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule